// File: doc/BRIEF.md
# Video Frame Writer Control and Status Registers

This block is the software-visible register set for the write side of a video frame buffer. A simple memory-mapped port with 16-bit registers reaches it. Software sets a run request. The writer datapath acts on that request only when it crosses a frame header boundary, and the block shows whether the writer is actually running. The datapath reports the end of every frame together with whether that frame was dropped or handed on to the reader. From these events the block keeps one counter of frames passed and one counter of frames dropped.

Two sticky event flags catch status-update and stable-video events from the datapath. Software clears each flag by writing 1 to its bit, and a single interrupt line is raised while either flag is set. A build-time switch adds a group of rate-control registers: one enable that selects locked rate conversion or free-running triple buffering, and two write-only frame-rate values that are driven straight to the datapath.

Top module: `vfw_regs`

## Requirements
- R1: After reset every register reads 0, the running indication `run_o` is 0 and `irq_o` is 0.
- R2: The control register (address 0) holds only bit 0, the run request. Bits 15:1 read as 0 whatever was written.
- R3: `run_o` changes only on a cycle with `frame_hdr` high. On the cycle after such a pulse it equals the run request, so clearing or setting the request has no effect until the next boundary. The status register (address 1) reads `run_o` in bit 0 and 0 in bits 15:1.
- R4: The passed-frame counter (address 3) increments by 1 on each `frame_end` with `frame_drop` low, and holds otherwise.
- R5: The dropped-frame counter (address 4) increments by 1 on each `frame_end` with `frame_drop` high, and holds otherwise.
- R6: Both counters wrap modulo 65536.
- R7: The event register (address 2) sets bit 1 on `evt_status` and bit 2 on `evt_stable`. Each bit stays set until a write has 1 in that bit position. A write with 0 in a bit position leaves that bit unchanged, and all other bits read 0.
- R8: `irq_o` is 1 exactly when at least one of the two event bits is set.
- R9: If an event pulse and a clearing write to the same bit fall in the same cycle, the bit ends set.
- R10: With rate support enabled, bit 0 of address 5 holds the locked-rate enable. It reads back in bit 0 and drives `rate_lock_o`.
- R11: With rate support enabled, addresses 6 and 7 store the input and output frame rates (16 bits each), which drive `in_rate_o` and `out_rate_o`. Reads of addresses 6 and 7 return 0.
- R12: Writes to the counter addresses 3 and 4 and to the status address 1 change nothing.
- R13: With rate support disabled (`LOCK_RATE_EN`=0), addresses 5 to 7 read 0, and `rate_lock_o`, `in_rate_o` and `out_rate_o` stay 0 whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 3 | Register address, shared by reads and writes |
| reg_wen | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| frame_hdr | input | 1 | Pulse when the writer reads a frame header (boundary) |
| frame_end | input | 1 | Pulse at the end of each processed frame |
| frame_drop | input | 1 | Qualifies `frame_end`: 1 for dropped, 0 for passed |
| evt_status | input | 1 | Status-update event pulse |
| evt_stable | input | 1 | Stable-video event pulse |
| run_o | output | 1 | Writer running indication |
| irq_o | output | 1 | OR of the sticky event flags |
| rate_lock_o | output | 1 | Locked rate conversion enable |
| in_rate_o | output | 16 | Input frame rate value |
| out_rate_o | output | 16 | Output frame rate value |

## Verification
Counter wraparound is the hardest case to reach from the ports, because it needs 65536 end-of-frame events. The stimulus holds `frame_end` high on consecutive cycles, which gives one event per clock, and then compares the counter against its value before the burst. The second hard case is an event pulse and a clearing write on the same cycle. The bench drives both on one negative edge and then reads the flag back.

// File: rtl/vfw_pkg.sv
// Package: shared register address map for the frame writer register block.
// Assumes a 3-bit word address; offsets are fixed by the block's software map.
package vfw_pkg;
    localparam int unsigned A_CTRL   = 0;
    localparam int unsigned A_STAT   = 1;
    localparam int unsigned A_EVT    = 2;
    localparam int unsigned A_PASS   = 3;
    localparam int unsigned A_DROP   = 4;
    localparam int unsigned A_RLOCK  = 5;
    localparam int unsigned A_INRATE = 6;
    localparam int unsigned A_OUTRATE= 7;
    localparam int unsigned EVT_FLAGS = 2;  // status-update (bit 1), stable (bit 2)
endpackage

// File: rtl/vfw_run_ctrl.sv
// Module: vfw_run_ctrl
// Holds the running indication and copies the run request into it only at a
// frame header boundary. Assumes frame_hdr is a single-cycle pulse.
module vfw_run_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic run_req,
    input  logic frame_hdr,
    output logic run
);
    // Purpose: sample the request at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)        run <= 1'b0;
        else if (frame_hdr) run <= run_req;
    end

    AST_RUN_ONLY_AT_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_hdr |=> $stable(run)); // R3
    AST_RUN_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        frame_hdr |=> (run == $past(run_req))); // R3
endmodule

// File: rtl/vfw_evt_counter.sv
// Module: vfw_evt_counter
// Free-running event counter that wraps at its width. Assumes bump is at most
// one event per cycle. Read-only: no write path exists.
module vfw_evt_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    output logic [CNT_W-1:0] count
);
    // Purpose: add one per qualified event, wrapping modulo 2**CNT_W.
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (bump) count <= count + CNT_W'(1);
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        bump |=> (count == $past(count) + CNT_W'(1))); // R4
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bump |=> $stable(count)); // R5
endmodule

// File: rtl/vfw_irq_flags.sv
// Module: vfw_irq_flags
// Sticky event flags, cleared per bit by a write-one mask. A set in the same
// cycle as a clear wins. Assumes events are pulses from the datapath.
module vfw_irq_flags #(
    parameter int unsigned N_FLAGS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_FLAGS-1:0] set_i,
    input  logic [N_FLAGS-1:0] clr_i,
    output logic [N_FLAGS-1:0] flags,
    output logic               irq
);
    // Purpose: clear the masked bits, then OR in new events.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_i) | set_i;
    end

    // Purpose: combine all flags into one interrupt line.
    always_comb irq = |flags;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & $past(flags & ~clr_i)) == $past(flags & ~clr_i))); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((flags & $past(set_i)) == $past(set_i))); // R9
    AST_IRQ_ON_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> irq); // R8
endmodule

// File: rtl/vfw_regs.sv
// Module: vfw_regs (top)
// Register block for the write side of a frame buffer: run request with
// boundary-aligned effect, running status, passed/dropped frame counters,
// sticky write-one-to-clear event flags and optional rate-control registers.
// Assumes one access per cycle, combinational reads, and datapath pulses.
module vfw_regs
    import vfw_pkg::*;
#(
    parameter int unsigned DATA_W       = 16,
    parameter int unsigned ADDR_W       = 3,
    parameter bit          LOCK_RATE_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wen,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              frame_hdr,
    input  logic              frame_end,
    input  logic              frame_drop,
    input  logic              evt_status,
    input  logic              evt_stable,
    output logic              run_o,
    output logic              irq_o,
    output logic              rate_lock_o,
    output logic [DATA_W-1:0] in_rate_o,
    output logic [DATA_W-1:0] out_rate_o
);
    localparam int unsigned PAD_EVT = DATA_W - EVT_FLAGS - 1;

    logic                 run_req;
    logic [DATA_W-1:0]    pass_cnt, drop_cnt;
    logic [EVT_FLAGS-1:0] evt_flags, evt_clr;
    logic                 wr_ctrl, wr_evt;

    assign wr_ctrl = reg_wen && (reg_addr == ADDR_W'(A_CTRL));
    assign wr_evt  = reg_wen && (reg_addr == ADDR_W'(A_EVT));
    assign evt_clr = wr_evt ? reg_wdata[EVT_FLAGS:1] : '0;

    // Purpose: hold the software run request.
    always_ff @(posedge clk) begin
        if (!rst_n)       run_req <= 1'b0;
        else if (wr_ctrl) run_req <= reg_wdata[0];
    end

    vfw_run_ctrl u_run (
        .clk(clk), .rst_n(rst_n), .run_req(run_req),
        .frame_hdr(frame_hdr), .run(run_o)
    );

    vfw_evt_counter #(.CNT_W(DATA_W)) u_pass (
        .clk(clk), .rst_n(rst_n), .bump(frame_end && !frame_drop), .count(pass_cnt)
    );

    vfw_evt_counter #(.CNT_W(DATA_W)) u_drop (
        .clk(clk), .rst_n(rst_n), .bump(frame_end && frame_drop), .count(drop_cnt)
    );

    vfw_irq_flags #(.N_FLAGS(EVT_FLAGS)) u_irq (
        .clk(clk), .rst_n(rst_n), .set_i({evt_stable, evt_status}),
        .clr_i(evt_clr), .flags(evt_flags), .irq(irq_o)
    );

    logic rate_map;
    generate
        if (LOCK_RATE_EN) begin : g_rate
            // Purpose: store the rate-control registers on their writes.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rate_lock_o <= 1'b0;
                    in_rate_o   <= '0;
                    out_rate_o  <= '0;
                end else if (reg_wen) begin
                    if (reg_addr == ADDR_W'(A_RLOCK))   rate_lock_o <= reg_wdata[0];
                    if (reg_addr == ADDR_W'(A_INRATE))  in_rate_o   <= reg_wdata;
                    if (reg_addr == ADDR_W'(A_OUTRATE)) out_rate_o  <= reg_wdata;
                end
            end
            assign rate_map = 1'b1;
        end else begin : g_norate
            assign rate_lock_o = 1'b0;
            assign in_rate_o   = '0;
            assign out_rate_o  = '0;
            assign rate_map    = 1'b0;
        end
    endgenerate

    // Purpose: select read data; write-only and unmapped addresses return 0.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(A_CTRL):  reg_rdata = {{(DATA_W-1){1'b0}}, run_req};
            ADDR_W'(A_STAT):  reg_rdata = {{(DATA_W-1){1'b0}}, run_o};
            ADDR_W'(A_EVT):   reg_rdata = {{PAD_EVT{1'b0}}, evt_flags, 1'b0};
            ADDR_W'(A_PASS):  reg_rdata = pass_cnt;
            ADDR_W'(A_DROP):  reg_rdata = drop_cnt;
            ADDR_W'(A_RLOCK): reg_rdata = {{(DATA_W-1){1'b0}}, rate_map & rate_lock_o};
            default:          reg_rdata = '0;
        endcase
    end

    AST_RATE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wen |=> ($stable(in_rate_o) && $stable(out_rate_o) && $stable(rate_lock_o))); // R11
    AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(A_CTRL)) |-> (reg_rdata[DATA_W-1:1] == '0)); // R2
endmodule

// File: tb/vfw_regs_tb.sv
// Directed bench for vfw_regs: one task per scenario, each checks its results.
module vfw_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wen = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic        frame_hdr = 1'b0, frame_end = 1'b0, frame_drop = 1'b0;
    logic        evt_status = 1'b0, evt_stable = 1'b0;
    logic [15:0] rdata, rdata_nl, in_rate, out_rate, in_rate_nl, out_rate_nl;
    logic        run, irq, rlock, run_nl, irq_nl, rlock_nl;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_pass = 0;
    int exp_drop = 0;

    always #2.5 clk = ~clk;  // 200 MHz

    vfw_regs dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
        .reg_wdata(reg_wdata), .reg_rdata(rdata), .frame_hdr(frame_hdr),
        .frame_end(frame_end), .frame_drop(frame_drop), .evt_status(evt_status),
        .evt_stable(evt_stable), .run_o(run), .irq_o(irq), .rate_lock_o(rlock),
        .in_rate_o(in_rate), .out_rate_o(out_rate)
    );

    vfw_regs #(.LOCK_RATE_EN(1'b0)) dut_nl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_nl), .frame_hdr(frame_hdr),
        .frame_end(frame_end), .frame_drop(frame_drop), .evt_status(evt_status),
        .evt_stable(evt_stable), .run_o(run_nl), .irq_o(irq_nl), .rate_lock_o(rlock_nl),
        .in_rate_o(in_rate_nl), .out_rate_o(out_rate_nl)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = rdata;
    endtask

    task automatic pulse_hdr();
        @(negedge clk); frame_hdr = 1'b1;
        @(negedge clk); frame_hdr = 1'b0;
    endtask

    task automatic frames(input int n, input logic drop);
        @(negedge clk); frame_end = 1'b1; frame_drop = drop;
        repeat (n) @(negedge clk);
        frame_end = 1'b0; frame_drop = 1'b0;
        if (drop) exp_drop = (exp_drop + n) % 65536;
        else      exp_pass = (exp_pass + n) % 65536;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            check($sformatf("R1 reset read addr %0d", a), d, 0);
        end
        check("R1 run_o after reset", run, 0);
        check("R1 irq_o after reset", irq, 0);
    endtask

    task automatic t_ctrl_bits();
        logic [15:0] d;
        wr(3'd0, 16'hFFFE); rd(3'd0, d); check("R2 control upper bits, go=0", d, 16'h0000);
        wr(3'd0, 16'hFFFF); rd(3'd0, d); check("R2 control only bit 0", d, 16'h0001);
        wr(3'd0, 16'h0000);
    endtask

    task automatic t_go_boundary();
        logic [15:0] d;
        wr(3'd0, 16'h0001);
        repeat (3) @(negedge clk);
        check("R3 run waits for boundary", run, 0);
        pulse_hdr();
        check("R3 run set at boundary", run, 1);
        rd(3'd1, d); check("R3 status reads running", d, 16'h0001);
        wr(3'd0, 16'h0000);
        repeat (3) @(negedge clk);
        rd(3'd1, d); check("R3 still running after clear", d, 16'h0001);
        pulse_hdr();
        check("R3 stopped at next boundary", run, 0);
        rd(3'd1, d); check("R3 status reads stopped", d, 16'h0000);
    endtask

    task automatic t_counters();
        logic [15:0] d;
        frames(5, 1'b0);
        frames(3, 1'b1);
        frames(2, 1'b0);
        repeat (2) @(negedge clk);
        rd(3'd3, d); check("R4 passed count", d, 16'(exp_pass));
        rd(3'd4, d); check("R5 dropped count", d, 16'(exp_drop));
        @(negedge clk); frame_drop = 1'b1;  // drop flag alone is no event
        @(negedge clk); frame_drop = 1'b0;
        rd(3'd4, d); check("R5 drop qualifier without frame_end", d, 16'(exp_drop));
    endtask

    task automatic t_wrap();
        logic [15:0] d;
        frames(65536 - exp_pass, 1'b0);
        rd(3'd3, d); check("R6 passed count wraps to 0", d, 16'd0);
        frames(1, 1'b0);
        rd(3'd3, d); check("R6 passed count after wrap", d, 16'd1);
    endtask

    task automatic t_readonly();
        logic [15:0] d;
        wr(3'd3, 16'h1234); wr(3'd4, 16'h5678); wr(3'd1, 16'h0001);
        rd(3'd3, d); check("R12 pass counter write ignored", d, 16'(exp_pass));
        rd(3'd4, d); check("R12 drop counter write ignored", d, 16'(exp_drop));
        rd(3'd1, d); check("R12 status write ignored", d, 16'h0000);
        check("R12 run unchanged by status write", run, 0);
    endtask

    task automatic t_irq();
        logic [15:0] d;
        @(negedge clk); evt_status = 1'b1;
        @(negedge clk); evt_status = 1'b0;
        rd(3'd2, d); check("R7 status-update flag bit 1", d, 16'h0002);
        check("R8 irq with one flag", irq, 1);
        @(negedge clk); evt_stable = 1'b1;
        @(negedge clk); evt_stable = 1'b0;
        rd(3'd2, d); check("R7 both flags", d, 16'h0006);
        wr(3'd2, 16'hFFF9); rd(3'd2, d); check("R7 write of 0 bits keeps flags", d, 16'h0006);
        wr(3'd2, 16'h0002); rd(3'd2, d); check("R7 clear bit 1 only", d, 16'h0004);
        check("R8 irq with stable flag", irq, 1);
        @(negedge clk);
        reg_addr = 3'd2; reg_wdata = 16'h0004; reg_wen = 1'b1; evt_stable = 1'b1;
        @(negedge clk); reg_wen = 1'b0; evt_stable = 1'b0;
        rd(3'd2, d); check("R9 set wins over clear", d, 16'h0004);
        wr(3'd2, 16'h0004); rd(3'd2, d); check("R7 clear bit 2", d, 16'h0000);
        check("R8 irq low with no flags", irq, 0);
    endtask

    task automatic t_rate();
        logic [15:0] d;
        wr(3'd5, 16'hFFFF); rd(3'd5, d); check("R10 rate enable reads bit 0", d, 16'h0001);
        check("R10 rate_lock_o set", rlock, 1);
        wr(3'd6, 16'd3000); wr(3'd7, 16'd6000);
        check("R11 input rate output", in_rate, 16'd3000);
        check("R11 output rate output", out_rate, 16'd6000);
        rd(3'd6, d); check("R11 input rate write-only", d, 16'h0000);
        rd(3'd7, d); check("R11 output rate write-only", d, 16'h0000);
        wr(3'd5, 16'h0000); check("R10 rate_lock_o cleared", rlock, 0);
        check("R13 no-rate build rate_lock_o", rlock_nl, 0);
        check("R13 no-rate build in rate", in_rate_nl, 16'h0000);
        check("R13 no-rate build out rate", out_rate_nl, 16'h0000);
        wr(3'd5, 16'h0001);
        reg_addr = 3'd5; #1;
        check("R13 no-rate build addr 5 reads 0", rdata_nl, 16'h0000);
        check("R13 no-rate build rate_lock_o after write", rlock_nl, 0);
    endtask

    initial begin : watchdog
        #900000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl_bits();
        t_go_boundary();
        t_counters();
        t_readonly();
        t_irq();
        t_rate();
        t_wrap();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule